// File: doc/BRIEF.md
# Way-Predicting DRAM Cache Lookup

This block runs the lookup for a set-associative cache kept in DRAM. Each DRAM row holds several complete sets. A set fills a run of consecutive columns: its first column is a tag block that holds the metadata for every way, and each following column holds the data of one way. When a request address arrives, the block splits it into a set index and a tag. It then picks a statically predicted way from the low tag bits.

The block issues two column reads one after the other without waiting: first the tag block, then the data block of the predicted way. It does no tag compare before the second read. When the tag block returns, all ways are compared at once while the predicted data is still on its way. A valid match in the predicted way is a fast hit, and the block returns the data it already fetched. A match in any other way is a slow hit, and the block sends one more column read for that way. No valid match is a miss, and the block reports the set and the static way to the replacement logic.

Only one lookup is in flight at a time. The request side is a ready/valid handshake. The result appears as a one-cycle valid pulse.

Top module: `wpc_lookup`

## Requirements
- R1: The request address splits into line offset bits [5:0], set index bits [17:6] and tag bits [31:13+5]. Every command carries row = set index >> 2. The tag block column is (set index mod 4) * 8.
- R2: The static way is tag bits [2:0], with the value 7 mapped to 0. The predicted data column is tag column + 1 + static way.
- R3: The first accepted command of a lookup is the tag read. The predicted data read is offered in the very next cycle, before any read data has returned.
- R4: A fast hit is a valid entry in the static way whose tag equals the request tag. The result then has kind 1 and way = static way, its data is the predicted block, and exactly two commands are sent.
- R5: A slow hit is a miss in the static way with a valid match in another way; the lowest such way wins. The result then has kind 2 and way = the matching way. A third command goes to tag column + 1 + way, and the result data is the block it returns.
- R6: A miss is a set with no valid matching entry. The result then has kind 3, way = static way and the request's set index, and only two commands are sent.
- R7: An entry whose valid bit is 0 never matches, even when its tag field equals the request tag.
- R8: req_ready is low from the cycle after a request is accepted until the result pulse. res_valid is high for exactly one cycle per request.
- R9: While cmd_valid is high and cmd_ready is low, cmd_valid stays high and cmd_row and cmd_col stay unchanged.
- R10: Tag entry w sits at bits [w*18 +: 18] of the tag block. Within an entry, bit 0 is valid, bit 1 is remapped, bits [3:2] are the re-reference value and bits [17:4] are the tag. The result reports the re-reference value and the remapped flag of the matched way on a hit, and of the static way on a miss.
- R11: In reset, req_ready is 1 and cmd_valid and res_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Request byte address |
| cmd_valid | output | 1 | Column read command valid |
| cmd_ready | input | 1 | DRAM accepts the command |
| cmd_row | output | 10 | Row of the command |
| cmd_col | output | 5 | Column of the command |
| rd_valid | input | 1 | One returned 64-byte block |
| rd_data | input | 512 | Returned block |
| res_valid | output | 1 | Result pulse |
| res_kind | output | 2 | 1 fast hit, 2 slow hit, 3 miss |
| res_way | output | 3 | Hit way, or static way on a miss |
| res_set | output | 12 | Set index of the request |
| res_static_way | output | 3 | Static way of the request |
| res_rrpv | output | 2 | Re-reference value of the selected entry |
| res_remap | output | 1 | Remapped flag of the selected entry |
| res_addr | output | 32 | Address of the finished request |
| res_data | output | 512 | Data block on a hit |

## Verification
The checks assume a DRAM side that returns exactly one block per accepted command, in the order the commands were accepted. They also assume read data never arrives for a command that was not issued. The bench drives the DRAM port from a fixed-latency in-order queue that only fills when a handshake is seen, so it keeps within these assumptions. The requester never raises req_valid while the block is busy.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

   typedef enum logic [1:0] {
      KIND_NONE = 2'd0,
      KIND_FAST = 2'd1,
      KIND_SLOW = 2'd2,
      KIND_MISS = 2'd3
   } wpc_kind_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_RUN  = 2'd1,
      PH_DONE = 2'd2
   } wpc_phase_e;

endpackage

// File: rtl/wpc_addr_map.sv
module wpc_addr_map #(
   parameter int LINE_W = 26,
   parameter int SET_W  = 12,
   parameter int SPR_W  = 2,
   parameter int CPS_W  = 3,
   parameter int WAYS   = 7,
   localparam int TAG_W = LINE_W - SET_W,
   localparam int ROW_W = SET_W - SPR_W,
   localparam int COL_W = SPR_W + CPS_W,
   localparam int WAY_W = CPS_W
) (
   input  logic [LINE_W-1:0] line_addr,
   output logic [SET_W-1:0]  set_idx,
   output logic [TAG_W-1:0]  tag,
   output logic [ROW_W-1:0]  row,
   output logic [COL_W-1:0]  base_col,
   output logic [WAY_W-1:0]  static_way
);

   logic [WAY_W-1:0] raw_way;

   assign set_idx  = line_addr[SET_W-1:0];
   assign tag      = line_addr[LINE_W-1:SET_W];
   assign row      = set_idx[SET_W-1:SPR_W];
   assign base_col = {set_idx[SPR_W-1:0], {CPS_W{1'b0}}};
   assign raw_way  = tag[WAY_W-1:0];

   // Ways that fall outside the data columns fold back into range.
   generate
      if (WAYS == (1 << WAY_W)) begin : g_direct
         assign static_way = raw_way;
      end else begin : g_fold
         localparam logic [WAY_W-1:0] WAYS_V = WAY_W'(WAYS);
         assign static_way = (raw_way >= WAYS_V) ? (raw_way - WAYS_V) : raw_way;
      end
   endgenerate

endmodule

// File: rtl/wpc_tag_cmp.sv
module wpc_tag_cmp #(
   parameter int WAYS  = 7,
   parameter int TAG_W = 14,
   parameter int WAY_W = 3,
   localparam int ENT_W = TAG_W + 4,
   localparam int SLOTS = 1 << WAY_W
) (
   input  logic [WAYS*ENT_W-1:0] tag_blk,
   input  logic [TAG_W-1:0]      req_tag,
   input  logic [WAY_W-1:0]      static_way,
   output logic                  pred_hit,
   output logic                  other_hit,
   output logic [WAY_W-1:0]      hit_way,
   output logic [1:0]            sel_rrpv,
   output logic                  sel_remap
);

   logic [SLOTS-1:0] hit_vec;
   logic [1:0]       rrpv_arr  [SLOTS];
   logic             remap_arr [SLOTS];
   logic [WAY_W-1:0] sel_way;

   generate
      for (genvar w = 0; w < SLOTS; w++) begin : g_slot
         if (w < WAYS) begin : g_way
            logic [ENT_W-1:0] ent;
            assign ent          = tag_blk[w*ENT_W +: ENT_W];
            assign hit_vec[w]   = ent[0] && (ent[ENT_W-1:4] == req_tag);
            assign rrpv_arr[w]  = ent[3:2];
            assign remap_arr[w] = ent[1];
         end else begin : g_pad
            assign hit_vec[w]   = 1'b0;
            assign rrpv_arr[w]  = 2'b00;
            assign remap_arr[w] = 1'b0;
         end
      end
   endgenerate

   // Lowest numbered non-predicted way wins among secondary matches.
   always_comb begin
      pred_hit  = 1'b0;
      other_hit = 1'b0;
      hit_way   = '0;
      for (int w = SLOTS - 1; w >= 0; w--) begin
         if (WAY_W'(w) == static_way) begin
            pred_hit = hit_vec[w];
         end else if (hit_vec[w]) begin
            other_hit = 1'b1;
            hit_way   = WAY_W'(w);
         end
      end
   end

   assign sel_way   = (!pred_hit && other_hit) ? hit_way : static_way;
   assign sel_rrpv  = rrpv_arr[sel_way];
   assign sel_remap = remap_arr[sel_way];

endmodule

// File: rtl/wpc_ctrl.sv
module wpc_ctrl
   import wpc_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int ROW_W     = 10,
   parameter int COL_W     = 5,
   parameter int WAY_W     = 3,
   parameter int TAG_BLK_W = 126,
   parameter int BLK_W     = 512
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [ADDR_W-1:0]    req_addr,
   output logic [ADDR_W-1:0]    addr_q,
   input  logic [ROW_W-1:0]     map_row,
   input  logic [COL_W-1:0]     map_base,
   input  logic [WAY_W-1:0]     map_sway,
   output logic                 cmd_valid,
   input  logic                 cmd_ready,
   output logic [ROW_W-1:0]     cmd_row,
   output logic [COL_W-1:0]     cmd_col,
   input  logic                 rd_valid,
   input  logic [BLK_W-1:0]     rd_data,
   output logic [TAG_BLK_W-1:0] tag_q,
   input  logic                 pred_hit,
   input  logic                 other_hit,
   input  logic [WAY_W-1:0]     hit_way,
   input  logic [1:0]           sel_rrpv,
   input  logic                 sel_remap,
   output logic                 res_valid,
   output logic [1:0]           res_kind,
   output logic [WAY_W-1:0]     res_way,
   output logic [1:0]           res_rrpv,
   output logic                 res_remap,
   output logic [BLK_W-1:0]     res_data
);

   wpc_phase_e       phase;
   logic [1:0]       iss_cnt;
   logic [1:0]       rcv_cnt;
   logic [BLK_W-1:0] data_q;
   wpc_kind_e        kind_now;
   wpc_kind_e        res_kind_q;
   logic [WAY_W-1:0] res_way_q;
   logic [1:0]       res_rrpv_q;
   logic             res_remap_q;
   logic             done;
   logic             run;

   assign run = (phase == PH_RUN);

   // The tag block is the first return; classification is valid after it.
   always_comb begin
      if (rcv_cnt == 2'd0)  kind_now = KIND_NONE;
      else if (pred_hit)    kind_now = KIND_FAST;
      else if (other_hit)   kind_now = KIND_SLOW;
      else                  kind_now = KIND_MISS;
   end

   // Tag and predicted reads need nothing from the compare; the third waits for it.
   always_comb begin
      cmd_valid = 1'b0;
      cmd_col   = map_base;
      case (iss_cnt)
         2'd0: begin
            cmd_valid = run;
            cmd_col   = map_base;
         end
         2'd1: begin
            cmd_valid = run;
            cmd_col   = map_base + COL_W'(map_sway) + COL_W'(1);
         end
         2'd2: begin
            cmd_valid = run && (kind_now == KIND_SLOW);
            cmd_col   = map_base + COL_W'(hit_way) + COL_W'(1);
         end
         default: begin
            cmd_valid = 1'b0;
            cmd_col   = map_base;
         end
      endcase
   end

   assign cmd_row = map_row;

   assign done = run && (((rcv_cnt == 2'd2) && (kind_now != KIND_SLOW)) ||
                         (rcv_cnt == 2'd3));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase       <= PH_IDLE;
         iss_cnt     <= '0;
         rcv_cnt     <= '0;
         addr_q      <= '0;
         tag_q       <= '0;
         data_q      <= '0;
         res_kind_q  <= KIND_NONE;
         res_way_q   <= '0;
         res_rrpv_q  <= '0;
         res_remap_q <= 1'b0;
      end else begin
         case (phase)
            PH_IDLE: begin
               if (req_valid) begin
                  addr_q  <= req_addr;
                  iss_cnt <= '0;
                  rcv_cnt <= '0;
                  phase   <= PH_RUN;
               end
            end
            PH_RUN: begin
               if (cmd_valid && cmd_ready) begin
                  iss_cnt <= iss_cnt + 2'd1;
               end
               if (rd_valid) begin
                  if (rcv_cnt == 2'd0) tag_q  <= rd_data[TAG_BLK_W-1:0];
                  else                 data_q <= rd_data;
                  rcv_cnt <= rcv_cnt + 2'd1;
               end
               if (done) begin
                  res_kind_q  <= kind_now;
                  res_way_q   <= (kind_now == KIND_SLOW) ? hit_way : map_sway;
                  res_rrpv_q  <= sel_rrpv;
                  res_remap_q <= sel_remap;
                  phase       <= PH_DONE;
               end
            end
            default: begin
               phase <= PH_IDLE;
            end
         endcase
      end
   end

   assign req_ready = (phase == PH_IDLE);
   assign res_valid = (phase == PH_DONE);
   assign res_kind  = res_kind_q;
   assign res_way   = res_way_q;
   assign res_rrpv  = res_rrpv_q;
   assign res_remap = res_remap_q;
   assign res_data  = data_q;

endmodule

// File: rtl/wpc_lookup.sv
module wpc_lookup
   import wpc_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int OFF_W        = 6,
   parameter int SET_W        = 12,
   parameter int SETS_PER_ROW = 4,
   parameter int COLS_PER_SET = 8,
   parameter int BLK_W        = 512,
   localparam int SPR_W     = $clog2(SETS_PER_ROW),
   localparam int CPS_W     = $clog2(COLS_PER_SET),
   localparam int WAY_W     = CPS_W,
   localparam int WAYS      = COLS_PER_SET - 1,
   localparam int LINE_W    = ADDR_W - OFF_W,
   localparam int TAG_W     = LINE_W - SET_W,
   localparam int ENT_W     = TAG_W + 4,
   localparam int TAG_BLK_W = WAYS * ENT_W,
   localparam int ROW_W     = SET_W - SPR_W,
   localparam int COL_W     = SPR_W + CPS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [ROW_W-1:0]  cmd_row,
   output logic [COL_W-1:0]  cmd_col,
   input  logic              rd_valid,
   input  logic [BLK_W-1:0]  rd_data,
   output logic              res_valid,
   output logic [1:0]        res_kind,
   output logic [WAY_W-1:0]  res_way,
   output logic [SET_W-1:0]  res_set,
   output logic [WAY_W-1:0]  res_static_way,
   output logic [1:0]        res_rrpv,
   output logic              res_remap,
   output logic [ADDR_W-1:0] res_addr,
   output logic [BLK_W-1:0]  res_data
);

   generate
      if (SETS_PER_ROW < 2 || (1 << SPR_W) != SETS_PER_ROW) begin : g_bad_spr
         $error("SETS_PER_ROW must be a power of two, at least 2");
      end
      if (COLS_PER_SET < 2 || (1 << CPS_W) != COLS_PER_SET) begin : g_bad_cps
         $error("COLS_PER_SET must be a power of two, at least 2");
      end
      if (TAG_BLK_W > BLK_W) begin : g_bad_blk
         $error("tag entries do not fit in one block");
      end
      if (TAG_W < WAY_W || SET_W <= SPR_W) begin : g_bad_addr
         $error("address split leaves too few tag or row bits");
      end
   endgenerate

   logic [ADDR_W-1:0]    addr_q;
   logic [TAG_W-1:0]     req_tag;
   logic [ROW_W-1:0]     map_row;
   logic [COL_W-1:0]     map_base;
   logic [WAY_W-1:0]     map_sway;
   logic [TAG_BLK_W-1:0] tag_q;
   logic                 pred_hit;
   logic                 other_hit;
   logic [WAY_W-1:0]     hit_way;
   logic [1:0]           sel_rrpv;
   logic                 sel_remap;

   wpc_addr_map #(
      .LINE_W (LINE_W),
      .SET_W  (SET_W),
      .SPR_W  (SPR_W),
      .CPS_W  (CPS_W),
      .WAYS   (WAYS)
   ) u_map (
      .line_addr  (addr_q[ADDR_W-1:OFF_W]),
      .set_idx    (res_set),
      .tag        (req_tag),
      .row        (map_row),
      .base_col   (map_base),
      .static_way (map_sway)
   );

   wpc_tag_cmp #(
      .WAYS  (WAYS),
      .TAG_W (TAG_W),
      .WAY_W (WAY_W)
   ) u_cmp (
      .tag_blk    (tag_q),
      .req_tag    (req_tag),
      .static_way (map_sway),
      .pred_hit   (pred_hit),
      .other_hit  (other_hit),
      .hit_way    (hit_way),
      .sel_rrpv   (sel_rrpv),
      .sel_remap  (sel_remap)
   );

   wpc_ctrl #(
      .ADDR_W    (ADDR_W),
      .ROW_W     (ROW_W),
      .COL_W     (COL_W),
      .WAY_W     (WAY_W),
      .TAG_BLK_W (TAG_BLK_W),
      .BLK_W     (BLK_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_addr  (req_addr),
      .addr_q    (addr_q),
      .map_row   (map_row),
      .map_base  (map_base),
      .map_sway  (map_sway),
      .cmd_valid (cmd_valid),
      .cmd_ready (cmd_ready),
      .cmd_row   (cmd_row),
      .cmd_col   (cmd_col),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data),
      .tag_q     (tag_q),
      .pred_hit  (pred_hit),
      .other_hit (other_hit),
      .hit_way   (hit_way),
      .sel_rrpv  (sel_rrpv),
      .sel_remap (sel_remap),
      .res_valid (res_valid),
      .res_kind  (res_kind),
      .res_way   (res_way),
      .res_rrpv  (res_rrpv),
      .res_remap (res_remap),
      .res_data  (res_data)
   );

   assign res_static_way = map_sway;
   assign res_addr       = addr_q;

endmodule

// File: rtl/wpc_lookup_chk.sv
module wpc_lookup_chk #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 6,
   parameter int SET_W  = 12,
   parameter int SPR_W  = 2,
   parameter int CPS_W  = 3,
   localparam int ROW_W = SET_W - SPR_W,
   localparam int COL_W = SPR_W + CPS_W,
   localparam int WAY_W = CPS_W,
   localparam int WAYS  = (1 << CPS_W) - 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [ROW_W-1:0]  cmd_row,
   input logic [COL_W-1:0]  cmd_col,
   input logic              res_valid,
   input logic [1:0]        res_kind,
   input logic [WAY_W-1:0]  res_way,
   input logic [ADDR_W-1:0] res_addr
);

   logic [2:0]        cmd_n;
   logic [ADDR_W-1:0] lat_addr;
   logic [WAY_W-1:0]  raw_sway;
   logic [WAY_W-1:0]  exp_sway;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_n    <= '0;
         lat_addr <= '0;
      end else if (req_valid && req_ready) begin
         cmd_n    <= '0;
         lat_addr <= req_addr;
      end else if (cmd_valid && cmd_ready && cmd_n != 3'd7) begin
         cmd_n <= cmd_n + 3'd1;
      end
   end

   assign raw_sway = res_addr[OFF_W+SET_W +: WAY_W];
   assign exp_sway = (raw_sway >= WAY_W'(WAYS)) ? raw_sway - WAY_W'(WAYS) : raw_sway;

   // R9
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_row) && $stable(cmd_col));

   // R8
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);

   // R8
   res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R3
   pred_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_ready && (cmd_col[CPS_W-1:0] == '0) |=> cmd_valid);

   // R1
   row_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> cmd_row == lat_addr[OFF_W+SPR_W +: ROW_W]);

   // R2
   static_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && res_kind != 2'd2 |-> res_way == exp_sway);

   // R5
   slow_cmds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && res_kind == 2'd2 |-> cmd_n == 3'd3);

   // R4
   two_cmds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && res_kind != 2'd2 |-> cmd_n == 3'd2);

   // R6
   kind_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> res_kind != 2'd0);

endmodule

bind wpc_lookup wpc_lookup_chk #(
   .ADDR_W (ADDR_W),
   .OFF_W  (OFF_W),
   .SET_W  (SET_W),
   .SPR_W  (SPR_W),
   .CPS_W  (CPS_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_addr  (req_addr),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_row   (cmd_row),
   .cmd_col   (cmd_col),
   .res_valid (res_valid),
   .res_kind  (res_kind),
   .res_way   (res_way),
   .res_addr  (res_addr)
);

// File: tb/test_wpc_lookup.sv
module test_wpc_lookup;

   localparam int ADDR_W = 32;
   localparam int SET_W  = 12;
   localparam int TAG_W  = 14;
   localparam int ENT_W  = 18;
   localparam int ROW_W  = 10;
   localparam int COL_W  = 5;
   localparam int BLK_W  = 512;
   localparam int LAT    = 2;
   localparam int NVEC   = 8;

   // {set, tag, hit way (7 = no way holds the tag)}
   localparam logic [28:0] VEC [NVEC] = '{
      {12'd0,    14'h0005, 3'd5},
      {12'd13,   14'h1232, 3'd2},
      {12'd4095, 14'h3FF1, 3'd4},
      {12'd6,    14'h0A03, 3'd7},
      {12'd2,    14'h0017, 3'd0},
      {12'd1027, 14'h2224, 3'd6},
      {12'd3,    14'h000F, 3'd7},
      {12'd9,    14'h1116, 3'd0}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [ADDR_W-1:0] req_addr = '0;
   logic              cmd_valid;
   logic              cmd_ready = 1'b0;
   logic [ROW_W-1:0]  cmd_row;
   logic [COL_W-1:0]  cmd_col;
   logic              rd_valid = 1'b0;
   logic [BLK_W-1:0]  rd_data = '0;
   logic              res_valid;
   logic [1:0]        res_kind;
   logic [2:0]        res_way;
   logic [SET_W-1:0]  res_set;
   logic [2:0]        res_static_way;
   logic [1:0]        res_rrpv;
   logic              res_remap;
   logic [ADDR_W-1:0] res_addr;
   logic [BLK_W-1:0]  res_data;

   always #10 clk = ~clk;

   wpc_lookup i_wpc_lookup (.*);

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   // In-order DRAM model with fixed latency
   logic [ROW_W+COL_W-1:0] q_rc [16];
   int               q_due [16];
   int               q_wr = 0;
   int               q_rd = 0;
   int               cyc = 0;
   logic             rdy_en = 1'b1;
   logic [BLK_W-1:0] tag_blk_m = '0;
   int               log_n = 0;
   logic [ROW_W-1:0] log_row [8];
   logic [COL_W-1:0] log_col [8];
   int               log_cyc [8];

   function automatic logic [BLK_W-1:0] dpat(input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c);
      logic [BLK_W-1:0] d;
      d = '0;
      d[31:0] = {17'h1A5A5, r, c};
      d[BLK_W-1 -: 8] = 8'hC3;
      return d;
   endfunction

   function automatic logic [BLK_W-1:0] mk_blk(input logic [TAG_W-1:0] t, input logic [2:0] h);
      logic [BLK_W-1:0] b;
      b = '0;
      for (int w = 0; w < 7; w++) begin
         logic [TAG_W-1:0] tw;
         tw = (w == int'(h)) ? t : ~t;
         b[w*ENT_W +: ENT_W] = {tw, 2'(w), 1'(w), 1'b1};
      end
      return b;
   endfunction

   always @(negedge clk) begin
      cyc = cyc + 1;
      rd_valid = 1'b0;
      rd_data  = '0;
      if (q_rd != q_wr && q_due[q_rd % 16] == cyc) begin
         logic [ROW_W+COL_W-1:0] rc;
         rc = q_rc[q_rd % 16];
         rd_valid = 1'b1;
         rd_data = (rc[2:0] == 3'd0) ? tag_blk_m : dpat(rc[ROW_W+COL_W-1:COL_W], rc[COL_W-1:0]);
         q_rd = q_rd + 1;
      end
      cmd_ready = rdy_en;
      if (cmd_valid && cmd_ready) begin
         q_rc[q_wr % 16]  = {cmd_row, cmd_col};
         q_due[q_wr % 16] = cyc + LAT;
         q_wr = q_wr + 1;
         if (log_n < 8) begin
            log_row[log_n] = cmd_row;
            log_col[log_n] = cmd_col;
            log_cyc[log_n] = cyc;
         end
         log_n = log_n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   bit               got;
   bit               busy_ok;
   logic [1:0]       r_kind;
   logic [2:0]       r_way;
   logic [SET_W-1:0] r_set;
   logic [1:0]       r_rrpv;
   logic             r_remap;
   logic [BLK_W-1:0] r_data;

   task automatic do_req(input logic [ADDR_W-1:0] a);
      log_n = 0;
      busy_ok = 1'b1;
      got = 1'b0;
      @(posedge clk); #2;
      req_valid = 1'b1;
      req_addr  = a;
      for (int i = 0; i < 100; i++) begin
         logic rr;
         @(negedge clk);
         rr = req_ready;
         @(posedge clk); #2;
         if (rr) break;
      end
      req_valid = 1'b0;
      for (int i = 0; i < 200 && !got; i++) begin
         @(negedge clk);
         if (res_valid) begin
            got     = 1'b1;
            r_kind  = res_kind;
            r_way   = res_way;
            r_set   = res_set;
            r_rrpv  = res_rrpv;
            r_remap = res_remap;
            r_data  = res_data;
         end else if (req_ready) begin
            busy_ok = 1'b0;
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog actual=expired expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R11: reset state
      chk(req_ready == 1'b1, "R11", "req_ready in reset", 64'(req_ready), 64'd1);
      chk(cmd_valid == 1'b0, "R11", "cmd_valid in reset", 64'(cmd_valid), 64'd0);
      chk(res_valid == 1'b0, "R11", "res_valid in reset", 64'(res_valid), 64'd0);
      @(posedge clk); #2;
      rst_n = 1'b1;

      for (int v = 0; v < NVEC; v++) begin
         logic [SET_W-1:0] s;
         logic [TAG_W-1:0] t;
         logic [2:0]       h, sw, ew;
         logic [1:0]       ek;
         logic [ROW_W-1:0] er;
         logic [COL_W-1:0] eb;
         s  = VEC[v][28:17];
         t  = VEC[v][16:3];
         h  = VEC[v][2:0];
         sw = (t[2:0] == 3'd7) ? 3'd0 : t[2:0];
         ek = (h == 3'd7) ? 2'd3 : (h == sw) ? 2'd1 : 2'd2;
         ew = (ek == 2'd2) ? h : sw;
         er = s[SET_W-1:2];
         eb = {s[1:0], 3'b000};
         tag_blk_m = mk_blk(t, h);
         do_req({t, s, 6'h15});
         chk(got, "R8", "result arrived", 64'(got), 64'd1);
         chk(busy_ok, "R8", "req_ready low while busy", 64'(busy_ok), 64'd1);
         // R4 R5 R6: classification
         chk(r_kind == ek, "R4/R5/R6 kind", "kind", 64'(r_kind), 64'(ek));
         // R2: static way
         chk(r_way == ew, "R2", "way", 64'(r_way), 64'(ew));
         chk(r_set == s, "R6", "set", 64'(r_set), 64'(s));
         // R10: metadata of selected entry
         chk(r_rrpv == ew[1:0] && r_remap == ew[0], "R10", "rrpv/remap",
             64'({r_rrpv, r_remap}), 64'({ew[1:0], ew[0]}));
         // R1: row and tag column
         chk(log_row[0] == er && log_col[0] == eb, "R1", "tag command",
             64'({log_row[0], log_col[0]}), 64'({er, eb}));
         chk(log_col[1] == eb + 5'(sw) + 5'd1, "R2", "predicted column",
             64'(log_col[1]), 64'(eb + 5'(sw) + 5'd1));
         // R3: back-to-back issue
         chk(log_cyc[1] == log_cyc[0] + 1, "R3", "second command cycle",
             64'(log_cyc[1]), 64'(log_cyc[0] + 1));
         if (ek == 2'd2) begin
            // R5: third read to the matching way
            chk(log_n == 3, "R5", "command count", 64'(log_n), 64'd3);
            chk(log_col[2] == eb + 5'(h) + 5'd1, "R5", "slow column",
                64'(log_col[2]), 64'(eb + 5'(h) + 5'd1));
            chk(r_data == dpat(er, eb + 5'(h) + 5'd1), "R5", "slow data",
                r_data[63:0], dpat(er, eb + 5'(h) + 5'd1) >> 0);
         end else begin
            chk(log_n == 2, "R4 R6", "command count", 64'(log_n), 64'd2);
            if (ek == 2'd1) begin
               // R4: predicted block returned
               chk(r_data == dpat(er, eb + 5'(sw) + 5'd1), "R4", "fast data",
                   r_data[63:0], dpat(er, eb + 5'(sw) + 5'd1) >> 0);
            end
         end
         @(negedge clk);
         chk(res_valid == 1'b0, "R8", "single pulse", 64'(res_valid), 64'd0);
      end

      // R7: matching tag with valid bit clear is a miss
      begin
         logic [BLK_W-1:0] b;
         b = mk_blk(14'h0101, 3'd1);
         b[1*ENT_W] = 1'b0;
         tag_blk_m = b;
         do_req({14'h0101, 12'd5, 6'h00});
         chk(r_kind == 2'd3, "R7", "invalid entry kind", 64'(r_kind), 64'd3);
         chk(log_n == 2, "R7", "invalid entry commands", 64'(log_n), 64'd2);
      end

      // R9: command held during back-pressure
      rdy_en = 1'b0;
      tag_blk_m = mk_blk(14'h0042, 3'd2);
      fork
         do_req({14'h0042, 12'd22, 6'h00});
         begin
            logic [ROW_W+COL_W-1:0] first_rc;
            bit held;
            held = 1'b1;
            repeat (3) @(negedge clk);
            first_rc = {cmd_row, cmd_col};
            for (int i = 0; i < 4; i++) begin
               @(negedge clk);
               if (!cmd_valid || {cmd_row, cmd_col} != first_rc) held = 1'b0;
            end
            chk(held, "R9", "command held", 64'({cmd_valid, cmd_row, cmd_col}), 64'({1'b1, first_rc}));
            chk(first_rc == {10'd5, 5'd16}, "R9", "stalled command address",
                64'(first_rc), 64'({10'd5, 5'd16}));
            #2 rdy_en = 1'b1;
         end
      join
      chk(r_kind == 2'd1 && r_way == 3'd2, "R9", "result after stall",
          64'({r_kind, r_way}), 64'({2'd1, 3'd2}));

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule